// File: doc/BRIEF.md
# Self-Timed Byte-Wide EEPROM Write Model

This block is a synthesizable behavioural model of a 2048-byte electrically erasable memory. The host sees an interface like an asynchronous static RAM, with active-low chip enable, output enable and write enable and a split data bus. The model samples that interface with a fast system clock. A byte write latches its address and data and then completes on its own. An internal sequencer first erases the target byte to all ones and then programs it. The sequencer also holds an open-drain ready/busy line low for the whole cycle.

While a cycle is running, a read returns a polling byte instead of array contents. Bit 7 of that byte is the complement of bit 7 of the data being written, and bits 6..0 are zero. A host can therefore detect completion either from the ready/busy line or by polling. Write strobes that arrive during a cycle are dropped. A single-cycle clear request erases the whole array to 0xFF, one location per clock. For a period after reset, both byte writes and clear requests are locked out. All times are parameters counted in system clock cycles.

The data path is deliberately not valid/ready. The host owns the bus timing, there is no back-pressure, and completion is reported only through the ready/busy line and polling.

Top module: `selftimed_eeprom`

## Requirements
- R1: When ce_n=0, oe_n=0 and we_n=1 and no cycle is running, data_oe is 1 and data_out equals the byte stored at addr. If ce_n=1 or oe_n=1, data_oe is 0.
- R2: A byte write is started by a low pulse on both ce_n and we_n while oe_n stays 1. Either signal may fall last and rise first. The address is taken when the pulse begins, at the later falling edge. The data is taken when the pulse ends, at the earlier rising edge.
- R3: A pulse during which oe_n is 0 does not start a write. A low pulse on we_n while ce_n stays 1 does not start a write.
- R4: After a completed write, the location holds exactly the new byte, whatever it held before. This includes bits going from 0 back to 1.
- R5: rb_drive_low (1 = pull the shared line low) goes to 1 within 6 cycles after the pulse ends. It stays 1 for exactly ERASE_CYCLES+PROG_CYCLES cycles and then returns to 0.
- R6: A read while a byte write is running gives data_oe=1 and data_out = {~d[7], 7'b0}, where d is the byte being written. A read while a clear is running returns 0x00.
- R7: Write pulses that begin while a cycle is running are ignored, even if they end after the cycle has finished. They start no new cycle and change no location.
- R8: For LOCKOUT_CYCLES cycles after reset, write pulses and clear requests start nothing, and rb_drive_low stays 0.
- R9: A one-cycle pulse on clear_req sets every location to 0xFF. rb_drive_low is 1 for exactly 2^ADDR_W cycles while this happens.
- R10: In reset and immediately after it, rb_drive_low is 0 and data_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte address |
| data_in | input | DATA_W | Write data from host |
| data_out | output | DATA_W | Read data to host, zero when not enabled |
| data_oe | output | 1 | Drive enable for the data bus |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| clear_req | input | 1 | One-cycle request to erase the whole array |
| rb_drive_low | output | 1 | Open-drain ready/busy: 1 pulls the line low |

## Verification
The hardest state to reach is a write pulse that starts while a cycle is busy but ends after the cycle has finished. A naive end-of-pulse trigger would start a write from such a pulse. The bench opens a long pulse in the middle of a running write and holds it past the end of the busy period. It then checks that no second busy run appears and that the target byte still reads 0xFF. Capture at opposite edges is exercised by changing address and data in the middle of a pulse. The bench expects the first address together with the second data byte.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ERASE = 2'd1,
    PH_PROG  = 2'd2,
    PH_WIPE  = 2'd3
  } eep_phase_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] synced
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
      end else begin
        s1 <= raw[i];
        s2 <= s1;
      end
    end
    assign synced[i] = s2;
  end
endmodule

// File: rtl/write_capture.sv
module write_capture #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              oe_s,
  input  logic              we_s,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              busy,
  input  logic              lock_done,
  output logic              start,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic active, act_q, armed_q;
  logic opens, closes;

  assign active = ~ce_s & ~we_s & oe_s;
  assign opens  = active & ~act_q;
  assign closes = ~active & act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      armed_q <= 1'b0;
      start   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      act_q <= active;
      start <= 1'b0;
      if (opens) begin
        armed_q <= ~busy & lock_done;
        if (~busy & lock_done) wr_addr <= addr;
      end else if (closes) begin
        armed_q <= 1'b0;
        if (armed_q & oe_s & ~busy) begin
          start   <= 1'b1;
          wr_data <= din;
        end
      end
    end
  end
endmodule

// File: rtl/write_sequencer.sv
module write_sequencer
  import eep_pkg::*;
#(
  parameter int ADDR_W         = 11,
  parameter int DATA_W         = 8,
  parameter int ERASE_CYCLES   = 20,
  parameter int PROG_CYCLES    = 40,
  parameter int LOCKOUT_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              clear_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              lock_done,
  output logic              poll_bit,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_din
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = $clog2(DEPTH + ERASE_CYCLES + PROG_CYCLES) + 1;
  localparam int LW    = $clog2(LOCKOUT_CYCLES + 1) + 1;
  localparam logic [CW-1:0] E_LAST = CW'(ERASE_CYCLES - 1);
  localparam logic [CW-1:0] P_LAST = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] W_LAST = CW'(DEPTH - 1);
  localparam logic [LW-1:0] L_MAX  = LW'(LOCKOUT_CYCLES);

  eep_phase_e    phase;
  logic [CW-1:0] cnt;
  logic [LW-1:0] lock_cnt;

  assign lock_done = (lock_cnt == L_MAX);
  assign busy      = (phase != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_cnt <= '0;
    else if (!lock_done) lock_cnt <= lock_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      poll_bit <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (lock_done) begin
          if (start) begin
            phase    <= PH_ERASE;
            cnt      <= E_LAST;
            poll_bit <= ~wr_data[DATA_W-1];
          end else if (clear_req) begin
            phase    <= PH_WIPE;
            cnt      <= '0;
            poll_bit <= 1'b0;
          end
        end
        PH_ERASE: if (cnt == '0) begin
          phase <= PH_PROG;
          cnt   <= P_LAST;
        end else cnt <= cnt - 1'b1;
        PH_PROG: if (cnt == '0) phase <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
        PH_WIPE: if (cnt == W_LAST) phase <= PH_IDLE;
                 else cnt <= cnt + 1'b1;
      endcase
    end
  end

  always_comb begin
    mem_we   = 1'b0;
    mem_addr = wr_addr;
    mem_din  = '1;
    unique case (phase)
      PH_ERASE: mem_we = (cnt == '0);
      PH_PROG: begin
        mem_we  = (cnt == '0);
        mem_din = wr_data;
      end
      PH_WIPE: begin
        mem_we   = 1'b1;
        mem_addr = cnt[ADDR_W-1:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/selftimed_eeprom.sv
module selftimed_eeprom #(
  parameter int ADDR_W         = 11,
  parameter int DATA_W         = 8,
  parameter int ERASE_CYCLES   = 20,
  parameter int PROG_CYCLES    = 40,
  parameter int LOCKOUT_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              clear_req,
  output logic              rb_drive_low
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [2:0]        strb_s;
  logic              wr_start, busy, lock_done, poll_bit, mem_we;
  logic [ADDR_W-1:0] wr_addr, mem_addr;
  logic [DATA_W-1:0] wr_data, mem_din;
  logic [DATA_W-1:0] mem [DEPTH];

  strobe_sync #(.N(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({ce_n, oe_n, we_n}), .synced(strb_s)
  );

  write_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .ce_s(strb_s[2]), .oe_s(strb_s[1]), .we_s(strb_s[0]),
    .addr(addr), .din(data_in), .busy(busy), .lock_done(lock_done),
    .start(wr_start), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  write_sequencer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_CYCLES(ERASE_CYCLES),
    .PROG_CYCLES(PROG_CYCLES), .LOCKOUT_CYCLES(LOCKOUT_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(wr_start), .clear_req(clear_req),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .lock_done(lock_done),
    .poll_bit(poll_bit), .mem_we(mem_we), .mem_addr(mem_addr), .mem_din(mem_din)
  );

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_din;
  end

  assign data_oe      = ~ce_n & ~oe_n & we_n;
  assign rb_drive_low = busy;

  always_comb begin
    if (!data_oe)  data_out = '0;
    else if (busy) data_out = {poll_bit, {(DATA_W-1){1'b0}}};
    else           data_out = mem[addr];
  end
endmodule

// File: rtl/eep_chk.sv
module eep_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_start,
  input logic              busy,
  input logic              lock_done,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] data_out,
  input logic              data_oe,
  input logic              rb_drive_low
);
  // R7
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> !busy);
  // R8
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_drive_low |-> lock_done);
  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wr_data));
  // R5
  min_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb_drive_low) |=> rb_drive_low);
  // R6
  poll_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && rb_drive_low) |-> (data_out[DATA_W-2:0] == '0));
endmodule

bind selftimed_eeprom eep_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .busy(busy),
  .lock_done(lock_done), .wr_data(wr_data), .data_out(data_out),
  .data_oe(data_oe), .rb_drive_low(rb_drive_low)
);

// File: tb/selftimed_eeprom_test.sv
`timescale 1ns/1ps
module selftimed_eeprom_test;
  localparam int AW = 11, DW = 8, EC = 20, PC = 40, LC = 100;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data_in = '0, data_out;
  logic data_oe, rb_drive_low;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, clear_req = 1'b0;

  int checks = 0, fails = 0;
  int run = 0, last_run = 0, runs_seen = 0;
  bit done = 1'b0;
  logic [DW-1:0] shadow [DEPTH];

  always #2.5 clk = ~clk;

  selftimed_eeprom #(.ADDR_W(AW), .DATA_W(DW), .ERASE_CYCLES(EC),
    .PROG_CYCLES(PC), .LOCKOUT_CYCLES(LC)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .clear_req(clear_req), .rb_drive_low(rb_drive_low));

  always @(negedge clk) begin
    if (rb_drive_low) run <= run + 1;
    else if (run > 0) begin
      last_run  <= run;
      runs_seen <= runs_seen + 1;
      run       <= 0;
    end
  end

  function automatic logic [DW-1:0] poll_val(input logic [DW-1:0] d);
    return {~d[DW-1], {(DW-1){1'b0}}};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit ce_ctl, input logic oe_v, input int hold,
                        input logic [AW-1:0] a2, input logic [DW-1:0] d2);
    @(negedge clk);
    addr = a; data_in = d; oe_n = oe_v;
    if (ce_ctl) begin we_n = 0; @(negedge clk); ce_n = 0; end
    else begin ce_n = 0; @(negedge clk); we_n = 0; end
    repeat (hold / 2) @(negedge clk);
    addr = a2; data_in = d2;
    repeat (hold - hold / 2) @(negedge clk);
    if (ce_ctl) begin ce_n = 1; @(negedge clk); we_n = 1; end
    else begin we_n = 1; @(negedge clk); ce_n = 1; end
    repeat (4) @(negedge clk);
    oe_n = 1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit ce_ctl);
    strobe(a, d, ce_ctl, 1'b1, 6, a, d);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (rb_drive_low && n < 5000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v, output logic en);
    @(negedge clk);
    addr = a; ce_n = 0; oe_n = 0; we_n = 1;
    #1 v = data_out; en = data_oe;
    @(negedge clk);
    ce_n = 1; oe_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    logic en;
    int rs;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(rb_drive_low == 0, "R10 busy in reset", rb_drive_low, 0);
    chk(data_oe == 0, "R10 oe in reset", data_oe, 0);
    rst_n = 1;
    @(negedge clk);
    chk(rb_drive_low == 0 && data_oe == 0, "R10 after reset", {rb_drive_low, data_oe}, 0);

    // R8: writes and clear during lockout
    rs = runs_seen;
    wr(11'h005, 8'h3C, 1'b0);
    @(negedge clk); clear_req = 1; @(negedge clk); clear_req = 0;
    repeat (10) @(negedge clk);
    chk(runs_seen == rs && rb_drive_low == 0, "R8 lockout", runs_seen - rs, 0);
    repeat (LC) @(negedge clk);

    // R9: whole-array clear
    rs = runs_seen;
    clear_req = 1; @(negedge clk); clear_req = 0;
    repeat (10) @(negedge clk);
    rd(11'h123, v, en);
    chk(en && v == 8'h00, "R6 poll during clear", v, 0);
    wait_idle();
    chk(runs_seen == rs + 1 && last_run == DEPTH, "R9 clear duration", last_run, DEPTH);
    for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] ra = AW'($urandom % DEPTH);
      rd(ra, v, en);
      chk(en && v == 8'hFF, "R9 cleared byte", v, 8'hFF);
    end

    // R4, R5: overwrite 0x00 with 0xA5
    wr(11'h010, 8'h00, 1'b0); wait_idle();
    rs = runs_seen;
    wr(11'h010, 8'hA5, 1'b0);
    wait_idle();
    chk(runs_seen == rs + 1 && last_run == EC + PC, "R5 busy length", last_run, EC + PC);
    rd(11'h010, v, en);
    chk(v == 8'hA5, "R4 erase then program", v, 8'hA5);
    shadow[11'h010] = 8'hA5;

    // R5, R6: polling read during write
    wr(11'h011, 8'h5A, 1'b1);
    chk(rb_drive_low == 1, "R5 busy after pulse", rb_drive_low, 1);
    rd(11'h011, v, en);
    chk(en && v == poll_val(8'h5A), "R6 polling data", v, poll_val(8'h5A));
    wait_idle();
    rd(11'h011, v, en);
    chk(v == 8'h5A, "R6 true data after", v, 8'h5A);
    shadow[11'h011] = 8'h5A;

    // R1: output float with oe_n high
    @(negedge clk); addr = 11'h011; ce_n = 0; oe_n = 1;
    #1 chk(data_oe == 0 && data_out == 0, "R1 float oe high", data_oe, 0);
    @(negedge clk); ce_n = 1;

    // R2: address at start, data at end, chip-enable controlled
    strobe(11'h030, 8'h11, 1'b1, 1'b1, 8, 11'h031, 8'hC3);
    wait_idle();
    rd(11'h030, v, en);
    chk(v == 8'hC3, "R2 end-of-pulse data", v, 8'hC3);
    rd(11'h031, v, en);
    chk(v == 8'hFF, "R2 start-of-pulse address", v, 8'hFF);
    shadow[11'h030] = 8'hC3;

    // R3: inhibited pulses
    rs = runs_seen;
    strobe(11'h040, 8'h00, 1'b0, 1'b0, 6, 11'h040, 8'h00);
    @(negedge clk); addr = 11'h041; data_in = 8'h00; we_n = 0;
    repeat (6) @(negedge clk); we_n = 1;
    repeat (8) @(negedge clk);
    chk(runs_seen == rs && rb_drive_low == 0, "R3 no cycle", runs_seen - rs, 0);
    rd(11'h040, v, en);
    chk(v == 8'hFF, "R3 oe low inhibit", v, 8'hFF);
    rd(11'h041, v, en);
    chk(v == 8'hFF, "R3 ce high inhibit", v, 8'hFF);

    // R7: pulses during busy, one outliving the cycle
    rs = runs_seen;
    wr(11'h050, 8'h77, 1'b0);
    wr(11'h051, 8'h00, 1'b1);
    strobe(11'h052, 8'h00, 1'b0, 1'b1, EC + PC, 11'h052, 8'h00);
    wait_idle();
    repeat (10) @(negedge clk);
    chk(runs_seen == rs + 1, "R7 single cycle", runs_seen - rs, 1);
    rd(11'h051, v, en);
    chk(v == 8'hFF, "R7 busy write dropped", v, 8'hFF);
    rd(11'h052, v, en);
    chk(v == 8'hFF, "R7 long pulse dropped", v, 8'hFF);
    shadow[11'h050] = 8'h77;

    // R1, R4: random writes then random reads against shadow
    for (int i = 0; i < 25; i++) begin
      logic [AW-1:0] ra = AW'($urandom % DEPTH);
      logic [DW-1:0] rv = DW'($urandom);
      wr(ra, rv, 1'($urandom % 2));
      wait_idle();
      shadow[ra] = rv;
      rd(ra, v, en);
      chk(en && v == rv, "R1 readback", v, rv);
    end
    for (int i = 0; i < 20; i++) begin
      logic [AW-1:0] ra = AW'($urandom % DEPTH);
      rd(ra, v, en);
      chk(en && v == shadow[ra], "R1 random read", v, shadow[ra]);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule